// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Access Splitter

This block sits between a requester that thinks in byte addresses and a 16-bit memory made of two 8-bit banks side by side. The even bank stores every byte whose address has bit 0 clear; the odd bank stores the rest. The requester asks for one byte or one 16-bit word, to read or to write, at any byte address. The block turns that request into one or two cycles on the memory side. Each cycle carries a word address, an even-bank select and an active-low odd-bank enable, and the block moves bytes between the two data lanes and the byte positions of the requester's register.

A word that starts on an even address needs one cycle with both banks enabled. A word that starts on an odd address straddles two memory words, so the block issues two cycles, one for each memory word, and swaps lanes on each. Byte order is little-endian: the byte at the lower address is the low-order byte of the register. Every memory cycle lasts until the memory raises its ready line. The requester sees a one-cycle done pulse only after the last cycle, with the read result already assembled.

Top module: `byte_lane_splitter`

## Requirements
- R1: After reset, req_done and mem_strobe are low and no memory cycle is issued until a request arrives.
- R2: Every memory cycle drives mem_addr with a word address (byte address bits AW-1..1). A byte at an even address uses mem_a0=0 and mem_bhe_n=1. A byte at an odd address uses mem_a0=1 and mem_bhe_n=0. A word at an even address uses mem_a0=0 and mem_bhe_n=0.
- R3: The even bank uses mem_wdata/mem_rdata bits 7..0 and the odd bank uses bits 15..8. A byte write places req_wdata[7:0] on the lane of its bank and drives the other lane to zero. req_wdata[15:8] has no effect on a byte write.
- R4: A word at an even address completes in exactly one memory cycle. req_wdata[7:0] goes to bits 7..0 and req_wdata[15:8] goes to bits 15..8, and a read returns mem_rdata unchanged.
- R5: A word at an odd address takes exactly two memory cycles. The first cycle uses the word address of the start byte with mem_a0=1 and mem_bhe_n=0, and carries the low byte on bits 15..8. The second cycle uses the next word address with mem_a0=0 and mem_bhe_n=1, and carries the high byte on bits 7..0.
- R6: A byte read returns the addressed byte in req_rdata[7:0], taken from its bank's lane, with req_rdata[15:8] zero.
- R7: req_done is a single-cycle pulse in the cycle after the final memory cycle completes. req_rdata holds the full result in that cycle, and for a split word the result combines both cycles.
- R8: While mem_strobe is high and mem_ready is low, the memory cycle stays pending with address, enables and write data held. A held cycle completes on the first edge where mem_ready is high.
- R9: The second word address of a split word wraps modulo the memory size, so a word at the top byte address pairs the last memory word with word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_done |
| req_addr | input | AW | Byte address of the operand |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write operand, low byte in bits 7..0 |
| req_rdata | output | 16 | Read result, valid with req_done |
| req_done | output | 1 | One-cycle completion pulse |
| mem_strobe | output | 1 | Memory cycle in progress |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW-1 | Word address |
| mem_a0 | output | 1 | Even-bank select, active low |
| mem_bhe_n | output | 1 | Odd-bank enable, active low |
| mem_wdata | output | 16 | Write lanes: even bank 7..0, odd bank 15..8 |
| mem_rdata | input | 16 | Read lanes: even bank 7..0, odd bank 15..8 |
| mem_ready | input | 1 | Memory cycle completes on this edge |

## Verification
The case that is hardest to reach from the ports is a split word whose two cycles are both held by a slow memory. It must keep its first-cycle byte across the stall, and the two lane swaps must recombine correctly when the pair wraps past the top word. The stimulus runs a two-bank memory model whose ready line inserts a configurable number of wait cycles. It writes and reads odd-address words under stalls and at the top byte address, then reads the bytes back one at a time so that each lane is checked on its own.

// File: rtl/byte_lane_splitter.sv
module byte_lane_splitter #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_we,
  input  logic [15:0]   req_wdata,
  output logic [15:0]   req_rdata,
  output logic          req_done,
  output logic          mem_strobe,
  output logic          mem_we,
  output logic [AW-2:0] mem_addr,
  output logic          mem_a0,
  output logic          mem_bhe_n,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ready
);

  localparam int WAW = AW - 1;

  logic          busy, second;
  logic [AW-1:0] addr_q;
  logic          word_q, we_q;
  logic [15:0]   wdata_q;
  logic [7:0]    lo_q;

  logic odd, split, last, xfer;
  logic [WAW-1:0] base_w;

  assign odd    = addr_q[0];
  assign split  = word_q & odd;
  assign last   = second | ~split;
  assign xfer   = busy & mem_ready;
  assign base_w = addr_q[AW-1:1];

  assign mem_strobe = busy;
  assign mem_we     = busy & we_q;
  assign mem_addr   = second ? base_w + {{(WAW-1){1'b0}}, 1'b1} : base_w;
  assign mem_a0     = second ? 1'b0 : odd;
  assign mem_bhe_n  = second ? 1'b1 : (word_q ? 1'b0 : ~odd);

  always_comb begin
    if (second)
      mem_wdata = {8'h00, wdata_q[15:8]};
    else if (word_q && !odd)
      mem_wdata = wdata_q;
    else if (odd)
      mem_wdata = {wdata_q[7:0], 8'h00};
    else
      mem_wdata = {8'h00, wdata_q[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      second    <= 1'b0;
      addr_q    <= '0;
      word_q    <= 1'b0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      lo_q      <= '0;
      req_done  <= 1'b0;
      req_rdata <= '0;
    end else begin
      req_done <= 1'b0;
      if (!busy && req_valid && !req_done) begin
        busy    <= 1'b1;
        second  <= 1'b0;
        addr_q  <= req_addr;
        word_q  <= req_word;
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end else if (xfer) begin
        if (!last) begin
          second <= 1'b1;
          lo_q   <= mem_rdata[15:8];
        end else begin
          busy     <= 1'b0;
          second   <= 1'b0;
          req_done <= 1'b1;
          if (second)
            req_rdata <= {mem_rdata[7:0], lo_q};
          else if (word_q)
            req_rdata <= mem_rdata;
          else
            req_rdata <= {8'h00, odd ? mem_rdata[15:8] : mem_rdata[7:0]};
        end
      end
    end
  end

endmodule

// File: rtl/byte_lane_splitter_chk.sv
module byte_lane_splitter_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_done,
  input logic          mem_strobe,
  input logic [AW-2:0] mem_addr,
  input logic          mem_a0,
  input logic          mem_bhe_n,
  input logic [15:0]   mem_wdata,
  input logic          mem_ready
);

  p_bank_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> !(mem_a0 && mem_bhe_n));

  p_hold_on_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && !mem_ready) |=> (mem_strobe && $stable(mem_addr) &&
      $stable(mem_a0) && $stable(mem_bhe_n) && $stable(mem_wdata)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  p_done_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(mem_strobe && mem_ready));

  p_idle_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !mem_strobe);

endmodule

bind byte_lane_splitter byte_lane_splitter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .mem_strobe(mem_strobe),
  .mem_addr(mem_addr), .mem_a0(mem_a0), .mem_bhe_n(mem_bhe_n),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/sim_byte_lane_splitter.sv
`timescale 1ns/1ps
module sim_byte_lane_splitter;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_word = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] req_rdata, mem_wdata, mem_rdata;
  logic req_done, mem_strobe, mem_we, mem_a0, mem_bhe_n, mem_ready;
  logic [AW-2:0] mem_addr;

  always #10 clk = ~clk;

  byte_lane_splitter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_we(req_we), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .req_done(req_done), .mem_strobe(mem_strobe),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_a0(mem_a0),
    .mem_bhe_n(mem_bhe_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  logic [15:0] mem [NW];
  logic [2:0] gap = 3'd0, wcnt;
  assign mem_ready = (wcnt >= gap);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
      for (int i = 0; i < NW; i++) mem[i] <= 16'h0000;
    end else if (mem_strobe && mem_ready) begin
      wcnt <= '0;
      if (mem_we) begin
        if (!mem_a0)    mem[mem_addr][7:0]  <= mem_wdata[7:0];
        if (!mem_bhe_n) mem[mem_addr][15:8] <= mem_wdata[15:8];
      end
    end else if (mem_strobe) begin
      wcnt <= wcnt + 3'd1;
    end
  end

  int n_run = 0, n_fail = 0, cyc_total = 0;
  bit finished = 0;
  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 100000 && !finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc_total);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [AW-2:0] lg_addr [2];
  logic lg_a0 [2], lg_bhe [2];
  logic [15:0] lg_wd [2];
  int n_xfer, n_clk;
  logic [15:0] rd;

  task automatic run_op(input logic we, input logic word, input logic [AW-1:0] a,
                        input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_word = word; req_addr = a; req_wdata = wd;
    n_xfer = 0; n_clk = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      n_clk++;
      if (mem_strobe && mem_ready) begin
        if (n_xfer < 2) begin
          lg_addr[n_xfer] = mem_addr; lg_a0[n_xfer] = mem_a0;
          lg_bhe[n_xfer] = mem_bhe_n; lg_wd[n_xfer] = mem_wdata;
        end
        n_xfer++;
      end
      if (req_done) break;
    end
    rd = req_rdata;
    chk("R7 done seen", {31'd0, req_done}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic check_lanes(input logic we, input logic word, input logic [AW-1:0] a,
                             input logic [15:0] wd);
    logic [AW-2:0] wa;
    logic [15:0] ew;
    wa = a[AW-1:1];
    if (word && !a[0])      ew = wd;
    else if (a[0])          ew = {wd[7:0], 8'h00};
    else                    ew = {8'h00, wd[7:0]};
    chk("R2 first cycle addr/a0/bhe_n", {lg_addr[0], lg_a0[0], lg_bhe[0]},
        {wa, a[0], (word ? 1'b0 : ~a[0])});
    if (we) chk("R3 first cycle write lanes", {16'd0, lg_wd[0]}, {16'd0, ew});
    if (word && a[0]) begin
      chk("R5 R9 second cycle addr/a0/bhe_n", {lg_addr[1], lg_a0[1], lg_bhe[1]},
          {wa + 1'b1, 1'b0, 1'b1});
      if (we) chk("R5 second cycle write lane", {16'd0, lg_wd[1]}, {24'd0, wd[15:8]});
    end
  endtask

  // {we, word, addr[8], wdata[16], exp_rdata[16], cycles[2]}
  localparam int NV = 14;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h10, 16'h1234, 16'h0000, 2'd1},
    {1'b1, 1'b1, 8'h21, 16'hABCD, 16'h0000, 2'd2},
    {1'b1, 1'b0, 8'h30, 16'h775A, 16'h0000, 2'd1},
    {1'b1, 1'b0, 8'h33, 16'h88C3, 16'h0000, 2'd1},
    {1'b0, 1'b1, 8'h10, 16'h0000, 16'h1234, 2'd1},
    {1'b0, 1'b1, 8'h21, 16'h0000, 16'hABCD, 2'd2},
    {1'b0, 1'b0, 8'h30, 16'h0000, 16'h005A, 2'd1},
    {1'b0, 1'b0, 8'h33, 16'h0000, 16'h00C3, 2'd1},
    {1'b0, 1'b1, 8'h11, 16'h0000, 16'h0012, 2'd2},
    {1'b0, 1'b0, 8'h22, 16'h0000, 16'h00AB, 2'd1},
    {1'b0, 1'b0, 8'h21, 16'h0000, 16'h00CD, 2'd1},
    {1'b0, 1'b1, 8'h30, 16'h0000, 16'h005A, 2'd1},
    {1'b0, 1'b1, 8'h32, 16'h0000, 16'hC300, 2'd1},
    {1'b0, 1'b1, 8'h33, 16'h0000, 16'h00C3, 2'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done low", {31'd0, req_done}, 32'd0);
    chk("R1 reset strobe low", {31'd0, mem_strobe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle without request", {30'd0, req_done, mem_strobe}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      run_op(v[43], v[42], v[41:34], v[33:18]);
      chk("R4 R5 cycle count", n_xfer, {30'd0, v[1:0]});
      check_lanes(v[43], v[42], v[41:34], v[33:18]);
      if (!v[43]) chk("R4 R5 R6 read data", {16'd0, rd}, {16'd0, v[17:2]});
      @(negedge clk);
      chk("R7 done single pulse", {31'd0, req_done}, 32'd0);
    end

    // stalled split word write and read
    gap = 3'd3;
    run_op(1'b1, 1'b1, 8'h41, 16'h5566);
    chk("R8 stalled split cycles", n_xfer, 32'd2);
    chk("R8 stall lengthens op", {31'd0, n_clk >= 8}, 32'd1);
    check_lanes(1'b1, 1'b1, 8'h41, 16'h5566);
    run_op(1'b0, 1'b1, 8'h41, 16'h0000);
    chk("R8 R7 stalled split read", {16'd0, rd}, 32'h5566);
    run_op(1'b0, 1'b0, 8'h42, 16'h0000);
    chk("R6 high byte alone", {16'd0, rd}, 32'h0055);
    gap = 3'd0;

    // wrap at top byte address
    run_op(1'b1, 1'b1, 8'hFF, 16'hBEEF);
    chk("R9 wrap cycles", n_xfer, 32'd2);
    check_lanes(1'b1, 1'b1, 8'hFF, 16'hBEEF);
    run_op(1'b0, 1'b0, 8'h00, 16'h0000);
    chk("R9 wrapped high byte in word 0", {16'd0, rd}, 32'h00BE);
    run_op(1'b0, 1'b0, 8'hFF, 16'h0000);
    chk("R9 low byte at top", {16'd0, rd}, 32'h00EF);
    run_op(1'b0, 1'b1, 8'hFF, 16'h0000);
    chk("R9 wrapped read", {16'd0, rd}, 32'hBEEF);
    run_op(1'b0, 1'b0, 8'h01, 16'h0000);
    chk("R3 neighbour byte untouched", {16'd0, rd}, 32'h0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule